// File: doc/BRIEF.md
# DMA Page Translation Unit

This block stands between devices that perform DMA and the system bus. A device presents a 24-bit DMA address together with a read/write flag and the number of address bits it can drive. The block widens that address to the full DMA space by forcing the missing upper bits to one, so narrow devices land at the top of the space. It then selects one of 2048 page descriptors held on chip and returns a 32-bit system bus address, the two cache hint bits of the page, and a two-bit fault code.

A CPU port reads and writes whole descriptor words, one per access. Each successful DMA access marks its descriptor as used, and a successful write also marks it as modified. The CPU sees both marks when it reads the descriptor back. When the CPU and a device contend in the same cycle, the CPU goes first and the device request is held off for that cycle.

Top module: `dma_xlate`

## Requirements
- R1: The page index is bits 23:13 of the widened DMA address. On success the response address is descriptor bits 31:13 followed by DMA address bits 12:0, which pass through unchanged.
- R2: For a `req_width` of 1 to 23, DMA address bits 23 down to `req_width` are forced to one before the lookup. A width of 0, or of 24 and above, uses the address unchanged.
- R3: A descriptor type (bits 1:0) of 00 gives fault code 01 (page not valid).
- R4: A descriptor type of 10 or 11 gives fault code 10 (malformed descriptor), including type 11 whose low bit is set.
- R5: With write-protect (descriptor bit 2) set, a DMA write gives fault code 11 and a DMA read completes with fault code 00.
- R6: The type faults take precedence over write protection. A write to a type-00 page with bit 2 set reports 01.
- R7: On success `rsp_ci` and `rsp_bx` carry descriptor bits 6 and 5. On any fault `rsp_addr`, `rsp_ci` and `rsp_bx` are all zero.
- R8: A successful access sets descriptor bit 3 (used). A successful write also sets bit 4 (modified). A faulting access changes neither bit. Both bits are visible through a CPU read.
- R9: A CPU write stores all 32 bits, including bits 4:3. A CPU read returns the stored word on `cpu_rdata` in the cycle after `cpu_en` is sampled.
- R10: `req_ready` is low in every cycle in which `cpu_en` is high. A request pending in such a cycle is accepted in the next free cycle and sees the CPU's write.
- R11: `rsp_valid` is high for exactly one cycle, the cycle after each accepted request, and is low at all other times.
- R12: During reset `req_ready` and `rsp_valid` are low, and reset clears every used and modified bit. The other descriptor contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_en | input | 1 | CPU descriptor access this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | 11 | Descriptor index |
| cpu_wdata | input | 32 | Descriptor word to store |
| cpu_rdata | output | 32 | Descriptor word, valid the cycle after a read |
| req_valid | input | 1 | DMA request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 24 | DMA address as driven by the device |
| req_write | input | 1 | 1 = DMA write, 0 = DMA read |
| req_width | input | 5 | Number of address bits the device drives |
| rsp_valid | output | 1 | Translation result present |
| rsp_addr | output | 32 | System bus address, zero on fault |
| rsp_fault | output | 2 | 00 ok, 01 not valid, 10 malformed, 11 write-protect |
| rsp_ci | output | 1 | Cache-inhibit hint of the page |
| rsp_bx | output | 1 | Full-block-transfer hint of the page |

## Verification
The hardest case to reach from the ports is a CPU write and a device request arriving in the same cycle for the same page. Only that case shows whether the stall is applied and whether the delayed lookup sees the new descriptor. The stimulus drives both in one cycle and checks `req_ready` in that cycle. It then checks that no response appears in the next cycle and that the response after it carries the address from the freshly written descriptor. The used and modified bits are invisible on the response path. They are reached by reading descriptors back over the CPU port after successful, faulting and write-protected accesses, and again after a reset.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE      = 2'b00,
    FLT_INVALID   = 2'b01,
    FLT_MALFORMED = 2'b10,
    FLT_WPROT     = 2'b11
  } fault_e;

  // descriptor bit positions (low byte)
  localparam int BIT_CI   = 6;
  localparam int BIT_BX   = 5;
  localparam int BIT_MOD  = 4;
  localparam int BIT_USED = 3;
  localparam int BIT_WP   = 2;

endpackage

// File: rtl/dma_addr_ext.sv
module dma_addr_ext #(
  parameter int DEV_AW = 24,
  parameter int WID_W  = 5
) (
  input  logic [DEV_AW-1:0] addr,
  input  logic [WID_W-1:0]  width,
  output logic [DEV_AW-1:0] ext
);

  logic              full;
  logic [DEV_AW-1:0] keep;

  always_comb begin
    full = (width == '0) || (int'(width) >= DEV_AW);
    keep = full ? {DEV_AW{1'b1}} : ({DEV_AW{1'b1}} >> (DEV_AW - int'(width)));
    ext  = addr | ~keep;
  end

  always_comb begin
    if (!full)
      AST_NARROW_TOP_ONES: assert ((ext >> width) == ({DEV_AW{1'b1}} >> width)); // R2
  end

endmodule

// File: rtl/dma_pde_table.sv
module dma_pde_table #(
  parameter int IDX_W = 11,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [1:0]       wr_flags,   // {modified, used}
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_mod,
  input  logic [IDX_W-1:0] flag_idx,
  output logic [1:0]       flag_out    // {modified, used}
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];
  logic [1:0]    flg [DEPTH];

  // descriptor body: plain synchronous RAM, no reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end

  // access marks: flops, so a CPU write and a lookup update can land together
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) flg[i] <= 2'b00;
    end else begin
      if (upd_en) flg[upd_idx] <= flg[upd_idx] | {upd_mod, 1'b1};
      if (wr_en)  flg[wr_idx]  <= wr_flags;  // CPU value wins on collision
    end
  end

  assign flag_out = flg[flag_idx];

  AST_MARK_SET: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !(wr_en && wr_idx == upd_idx)) |=> flg[$past(upd_idx)][0]); // R8

  AST_MOD_SET: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_mod && !(wr_en && wr_idx == upd_idx)) |=> flg[$past(upd_idx)][1]); // R8

endmodule

// File: rtl/dma_pde_check.sv
module dma_pde_check
  import dma_xlate_pkg::*;
#(
  parameter int SYS_AW  = 32,
  parameter int PG_BITS = 13
) (
  input  logic [SYS_AW-PG_BITS-1:0] page,
  input  logic [1:0]                dtype,
  input  logic                      wp,
  input  logic                      ci_in,
  input  logic                      bx_in,
  input  logic                      is_write,
  input  logic [PG_BITS-1:0]        offset,
  output fault_e                    fault,
  output logic [SYS_AW-1:0]         phys,
  output logic                      ci,
  output logic                      bx
);

  always_comb begin
    if (dtype[1])             fault = FLT_MALFORMED;
    else if (!dtype[0])       fault = FLT_INVALID;
    else if (wp && is_write)  fault = FLT_WPROT;
    else                      fault = FLT_NONE;
  end

  always_comb begin
    if (fault == FLT_NONE) begin
      phys = {page, offset};
      ci   = ci_in;
      bx   = bx_in;
    end else begin
      phys = '0;
      ci   = 1'b0;
      bx   = 1'b0;
    end
  end

endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
  import dma_xlate_pkg::*;
#(
  parameter int DEV_AW  = 24,
  parameter int SYS_AW  = 32,
  parameter int PG_BITS = 13,
  parameter int WID_W   = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cpu_en,
  input  logic                        cpu_we,
  input  logic [DEV_AW-PG_BITS-1:0]   cpu_idx,
  input  logic [SYS_AW-1:0]           cpu_wdata,
  output logic [SYS_AW-1:0]           cpu_rdata,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [DEV_AW-1:0]           req_addr,
  input  logic                        req_write,
  input  logic [WID_W-1:0]            req_width,
  output logic                        rsp_valid,
  output logic [SYS_AW-1:0]           rsp_addr,
  output logic [1:0]                  rsp_fault,
  output logic                        rsp_ci,
  output logic                        rsp_bx
);

  localparam int IDX_W = DEV_AW - PG_BITS;
  localparam logic [SYS_AW-1:0] MARK_MASK =
    (SYS_AW'(1) << BIT_MOD) | (SYS_AW'(1) << BIT_USED);

  logic [DEV_AW-1:0]  ext_addr;
  logic               accept;
  logic               rd_en;
  logic [IDX_W-1:0]   rd_idx;
  logic [SYS_AW-1:0]  desc_q;
  logic [1:0]         flag_out;

  logic               rsp_vq;
  logic               wr_q;
  logic [IDX_W-1:0]   idx_q;
  logic [PG_BITS-1:0] off_q;
  logic [IDX_W-1:0]   cpu_idx_q;

  fault_e             chk_fault;
  logic [SYS_AW-1:0]  chk_phys;
  logic               chk_ci;
  logic               chk_bx;

  dma_addr_ext #(.DEV_AW(DEV_AW), .WID_W(WID_W)) u_ext (
    .addr  (req_addr),
    .width (req_width),
    .ext   (ext_addr)
  );

  assign req_ready = !rst && !cpu_en;
  assign accept    = req_valid && req_ready;
  assign rd_en     = (cpu_en && !cpu_we) || accept;
  assign rd_idx    = cpu_en ? cpu_idx : ext_addr[DEV_AW-1:PG_BITS];

  dma_pde_table #(.IDX_W(IDX_W), .DW(SYS_AW)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .rd_data  (desc_q),
    .wr_en    (cpu_en && cpu_we),
    .wr_idx   (cpu_idx),
    .wr_data  (cpu_wdata),
    .wr_flags ({cpu_wdata[BIT_MOD], cpu_wdata[BIT_USED]}),
    .upd_en   (rsp_vq && chk_fault == FLT_NONE),
    .upd_idx  (idx_q),
    .upd_mod  (wr_q),
    .flag_idx (cpu_idx_q),
    .flag_out (flag_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vq    <= 1'b0;
      wr_q      <= 1'b0;
      idx_q     <= '0;
      off_q     <= '0;
      cpu_idx_q <= '0;
    end else begin
      rsp_vq <= accept;
      if (accept) begin
        wr_q  <= req_write;
        idx_q <= ext_addr[DEV_AW-1:PG_BITS];
        off_q <= ext_addr[PG_BITS-1:0];
      end
      if (cpu_en) cpu_idx_q <= cpu_idx;
    end
  end

  dma_pde_check #(.SYS_AW(SYS_AW), .PG_BITS(PG_BITS)) u_check (
    .page     (desc_q[SYS_AW-1:PG_BITS]),
    .dtype    (desc_q[1:0]),
    .wp       (desc_q[BIT_WP]),
    .ci_in    (desc_q[BIT_CI]),
    .bx_in    (desc_q[BIT_BX]),
    .is_write (wr_q),
    .offset   (off_q),
    .fault    (chk_fault),
    .phys     (chk_phys),
    .ci       (chk_ci),
    .bx       (chk_bx)
  );

  assign rsp_valid = rsp_vq;
  assign rsp_addr  = rsp_vq ? chk_phys : '0;
  assign rsp_fault = rsp_vq ? chk_fault : FLT_NONE;
  assign rsp_ci    = rsp_vq && chk_ci;
  assign rsp_bx    = rsp_vq && chk_bx;

  assign cpu_rdata = (desc_q & ~MARK_MASK)
                   | (SYS_AW'(flag_out[1]) << BIT_MOD)
                   | (SYS_AW'(flag_out[0]) << BIT_USED);

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && req_ready) |-> rsp_valid); // R11

  AST_RSP_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready)); // R11

  AST_OFFSET_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 2'b00) |-> rsp_addr[PG_BITS-1:0] == $past(ext_addr[PG_BITS-1:0])); // R1

  AST_WPROT_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 2'b11) |-> $past(req_write)); // R5

  AST_FAULT_BLANKS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'b00) |-> (rsp_addr == '0 && !rsp_ci && !rsp_bx)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_addr == '0 && rsp_fault == 2'b00)); // R11

endmodule

// File: tb/dma_xlate_tb.sv
module dma_xlate_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_en, cpu_we;
  logic [10:0] cpu_idx;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        req_valid, req_ready, req_write;
  logic [23:0] req_addr;
  logic [4:0]  req_width;
  logic        rsp_valid, rsp_ci, rsp_bx;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_fault;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dma_xlate u_dut (
    .clk(clk), .rst(rst),
    .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_idx(cpu_idx),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_width(req_width),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .rsp_ci(rsp_ci), .rsp_bx(rsp_bx)
  );

  // {desc[32], addr[24], width[5], wr[1], idx[11], exp_addr[32], fault[2], ci, bx}
  localparam int NV = 12;
  localparam logic [108:0] VECS [NV] = '{
    {32'h1234A001, 24'h002ABC, 5'd24, 1'b0, 11'h001, 32'h1234AABC, 2'b00, 1'b0, 1'b0},
    {32'hFFFFE061, 24'h123456, 5'd24, 1'b1, 11'h091, 32'hFFFFF456, 2'b00, 1'b1, 1'b1},
    {32'h55554000, 24'h004000, 5'd24, 1'b0, 11'h002, 32'h00000000, 2'b01, 1'b0, 1'b0},
    {32'h00002003, 24'h006000, 5'd24, 1'b0, 11'h003, 32'h00000000, 2'b10, 1'b0, 1'b0},
    {32'h00002002, 24'h008000, 5'd24, 1'b1, 11'h004, 32'h00000000, 2'b10, 1'b0, 1'b0},
    {32'h0ABC0005, 24'h00A010, 5'd24, 1'b1, 11'h005, 32'h00000000, 2'b11, 1'b0, 1'b0},
    {32'h0ABC0005, 24'h00C010, 5'd24, 1'b0, 11'h006, 32'h0ABC0010, 2'b00, 1'b0, 1'b0},
    {32'h80000041, 24'h001234, 5'd16, 1'b0, 11'h7F8, 32'h80001234, 2'b00, 1'b1, 1'b0},
    {32'h40002021, 24'h000ABC, 5'd12, 1'b0, 11'h7FF, 32'h40003ABC, 2'b00, 1'b0, 1'b1},
    {32'h70000001, 24'h800000, 5'd0,  1'b1, 11'h400, 32'h70000000, 2'b00, 1'b0, 1'b0},
    {32'h00004001, 24'h0E0000, 5'd20, 1'b0, 11'h7F0, 32'h00004000, 2'b00, 1'b0, 1'b0},
    {32'h00000004, 24'h00E000, 5'd24, 1'b1, 11'h007, 32'h00000000, 2'b01, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [10:0] idx, input logic [31:0] data);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_idx = idx; cpu_wdata = data;
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [10:0] idx, output logic [31:0] data);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b0; cpu_idx = idx;
    @(negedge clk);
    cpu_en = 1'b0;
    data = cpu_rdata;
  endtask

  task automatic lookup(input logic [23:0] a, input logic [4:0] w, input logic wr,
                        output logic [31:0] ra, output logic [1:0] rf,
                        output logic rci, output logic rbx,
                        output logic v_now, output logic v_after);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_width = w; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    v_now = rsp_valid; ra = rsp_addr; rf = rsp_fault; rci = rsp_ci; rbx = rsp_bx;
    @(negedge clk);
    v_after = rsp_valid;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] ra, rd;
    logic [1:0]  rf;
    logic        rci, rbx, vn, va;

    rst = 1'b1; cpu_en = 1'b0; cpu_we = 1'b0; cpu_idx = '0; cpu_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_width = 5'd24;
    repeat (3) @(negedge clk);
    check("R12 ready low in reset", {31'b0, req_ready}, 32'd0);
    check("R12 rsp_valid low in reset", {31'b0, rsp_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 ready idle", {31'b0, req_ready}, 32'd1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [31:0] d, ea;
      logic [23:0] a;
      logic [4:0]  w;
      logic        wr, eci, ebx;
      logic [10:0] ix;
      logic [1:0]  ef;
      {d, a, w, wr, ix, ea, ef, eci, ebx} = VECS[i];
      cpu_wr(ix, d);
      lookup(a, w, wr, ra, rf, rci, rbx, vn, va);
      check("R11 rsp_valid pulse", {31'b0, vn}, 32'd1);
      check("R11 rsp_valid drops", {31'b0, va}, 32'd0);
      if (w != 5'd24 && w != 5'd0) check("R2 narrow addr", ra, ea);
      else                         check("R1 addr", ra, ea);
      if (ef == 2'b01 && d[2])     check("R6 fault order", {30'b0, rf}, {30'b0, ef});
      else if (ef == 2'b01)        check("R3 invalid", {30'b0, rf}, {30'b0, ef});
      else if (ef == 2'b10)        check("R4 malformed", {30'b0, rf}, {30'b0, ef});
      else if (d[2])               check("R5 wprot", {30'b0, rf}, {30'b0, ef});
      else                         check("R1 no fault", {30'b0, rf}, {30'b0, ef});
      check("R7 hints", {30'b0, rci, rbx}, {30'b0, eci, ebx});
    end

    // marks: write success, read success, faults
    cpu_rd(11'h091, rd); check("R8 used+mod on write", rd, 32'hFFFFE079);
    cpu_rd(11'h001, rd); check("R8 used on read", rd, 32'h1234A009);
    cpu_rd(11'h005, rd); check("R8 wprot fault no mark", rd, 32'h0ABC0005);
    cpu_rd(11'h003, rd); check("R8 malformed no mark", rd, 32'h00002003);
    cpu_rd(11'h006, rd); check("R8 wp page read marks used", rd, 32'h0ABC000D);

    // full-word CPU store incl. mark bits
    cpu_wr(11'h100, 32'hCAFE1F9A);
    cpu_rd(11'h100, rd); check("R9 cpu readback", rd, 32'hCAFE1F9A);
    cpu_wr(11'h100, 32'h00000000);
    cpu_rd(11'h100, rd); check("R9 cpu clears marks", rd, 32'h00000000);

    // CPU and DMA in the same cycle, same page
    cpu_wr(11'h200, 32'h00000000);
    @(negedge clk);
    cpu_en = 1'b1; cpu_we = 1'b1; cpu_idx = 11'h200; cpu_wdata = 32'h30000001;
    req_valid = 1'b1; req_addr = 24'h400000; req_width = 5'd24; req_write = 1'b0;
    #1 check("R10 ready low on cpu", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    cpu_en = 1'b0; cpu_we = 1'b0;
    #1 check("R10 ready back", {31'b0, req_ready}, 32'd1);
    check("R11 no rsp while stalled", {31'b0, rsp_valid}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 stalled rsp valid", {31'b0, rsp_valid}, 32'd1);
    check("R10 sees cpu write", rsp_addr, 32'h30000010 & 32'hFFFFE000);

    // reset clears marks only
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    check("R12 ready low with request in reset", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    check("R12 no rsp in reset", {31'b0, rsp_valid}, 32'd0);
    req_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
    check("R12 no rsp after reset", {31'b0, rsp_valid}, 32'd0);
    cpu_rd(11'h091, rd); check("R12 marks cleared", rd, 32'hFFFFE061);

    finish_run();
  end

endmodule